// File: doc/BRIEF.md
# Cycle-Prescaled Reloading Interrupt Counter

This block raises a level-sensitive, maskable interrupt request for a CPU after a programmable number of prescaled CPU cycles. An 8-bit counter counts upward. It is stepped once every 114 CPU cycles, and each CPU cycle is marked by a one-cycle enable pulse. When a step finds the counter at 0xFF, the counter reloads from an 8-bit latch and the interrupt request is raised. The request stays raised until software clears it.

Software controls the block with single-cycle register writes. Each write carries a CPU address and a data byte. Only the address bits selected by the mask 0xF0CF are decoded, so each register also appears at mirror addresses. Software writes the reload latch one nibble at a time. A control write sets two enable bits and can restart the count. An acknowledge write clears the request and can re-arm counting from the stored "repeat" bit.

Top module: `irqc_top`

## Requirements
- R1: After reset the request output is low, both enable bits are 0, and the counter, latch and prescaler are 0. No request is raised until a control write sets enable bit 1.
- R2: A write whose address ANDed with 0xF0CF equals 0xF000 stores data[3:0] in latch bits [3:0]. A write whose masked address is 0xF002 or 0xF040 stores data[3:0] in latch bits [7:4]. Data bits [7:4] are ignored in both cases.
- R3: A control write (masked address 0xF004 or 0xF080) stores data[1:0] as the enable bits {run, repeat} and clears the request from the next cycle. When data[1] is 1, the same write also loads the counter from the latch and restarts the prescaler.
- R4: An acknowledge write (masked address 0xF003, 0xF006 or 0xF0C0) clears the request, restarts the prescaler, and sets both enable bits to the current value of enable bit 0. It does not reload the counter.
- R5: While enable bit 1 is 1, the counter steps on the first CPU cycle (cpu_ce high) after a prescaler restart and then on every 114th CPU cycle after that. Cycles with cpu_ce low do not count. The cycle of a control or acknowledge write does not count either.
- R6: A step at count 0xFF reloads the counter from the latch and sets the request. Any other step adds 1. With latch value L, the request therefore appears on CPU cycle 1 + (255 − L) × 114 after a loading control write.
- R7: Once raised, the request stays high through later wraps until a control or acknowledge write clears it.
- R8: While enable bit 1 is 0, the counter and the prescaler hold their values.
- R9: Writes whose masked address matches none of the listed values have no effect. Address bits [11:8] and [5:4] never take part in the decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_ce | input | 1 | One-cycle pulse marking a CPU cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | CPU address of the write |
| wr_data | input | 8 | Data byte of the write |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions assume that the write strobe is a clean single-cycle pulse with address and data stable in that cycle, and that cpu_ce may take any pattern. The prescaler window check also assumes that counting only resumes after a control or acknowledge write, which the register map guarantees. The stimulus drives every write as one strobe cycle set up away from the clock edge. It runs cpu_ce both held high and alternating, and it only ever re-arms counting through loading control writes or acknowledge writes.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int ADDR_W = 16;
  localparam logic [ADDR_W-1:0] DEC_MASK = 16'hF0CF;

  typedef enum logic [2:0] {
    WK_NONE,
    WK_LAT_LO,
    WK_LAT_HI,
    WK_CTRL,
    WK_ACK
  } wr_kind_e;

  function automatic wr_kind_e classify(input logic [ADDR_W-1:0] a);
    wr_kind_e k;
    case (a & DEC_MASK)
      16'hF000:                     k = WK_LAT_LO;
      16'hF002, 16'hF040:           k = WK_LAT_HI;
      16'hF004, 16'hF080:           k = WK_CTRL;
      16'hF003, 16'hF006, 16'hF0C0: k = WK_ACK;
      default:                      k = WK_NONE;
    endcase
    return k;
  endfunction
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              lat_lo_we,
  output logic              lat_hi_we,
  output logic              ctrl_we,
  output logic              ack_we,
  output logic [NIB_W-1:0]  nib,
  output logic [1:0]        ctrl_bits
);
  wr_kind_e kind;
  logic     unused_hi;

  always_comb begin
    kind      = wr_en ? classify(wr_addr) : WK_NONE;
    lat_lo_we = (kind == WK_LAT_LO);
    lat_hi_we = (kind == WK_LAT_HI);
    ctrl_we   = (kind == WK_CTRL);
    ack_we    = (kind == WK_ACK);
  end

  assign nib       = wr_data[NIB_W-1:0];
  assign ctrl_bits = wr_data[1:0];
  assign unused_hi = ^wr_data[DATA_W-1:NIB_W];
endmodule

// File: rtl/irqc_prescaler.sv
module irqc_prescaler #(
  parameter int PERIOD = 114,
  localparam int PW    = $clog2(PERIOD)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic run,
  input  logic restart,
  output logic tick
);
  logic [PW-1:0] presc_q;

  function automatic logic [PW-1:0] next_presc(input logic [PW-1:0] p);
    return (p == '0) ? PW'(PERIOD - 1) : p - 1'b1;
  endfunction

  assign tick = ce && run && !restart && (presc_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)           presc_q <= '0;
    else if (restart)     presc_q <= '0;
    else if (ce && run)   presc_q <= next_presc(presc_q);
  end
endmodule

// File: rtl/irqc_counter.sv
module irqc_counter #(
  parameter int CNT_W  = 8,
  localparam int NIB_W = CNT_W / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lat_lo_we,
  input  logic             lat_hi_we,
  input  logic [NIB_W-1:0] nib,
  input  logic             load,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] latch,
  output logic             wrap
);
  logic [1:0] half_we;

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c,
                                            input logic [CNT_W-1:0] rl);
    return (c == '1) ? rl : c + 1'b1;
  endfunction

  assign half_we = {lat_hi_we, lat_lo_we};
  assign wrap    = tick && (count == '1);

  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk) begin
      if (!rst_n)          latch[h*NIB_W +: NIB_W] <= '0;
      else if (half_we[h]) latch[h*NIB_W +: NIB_W] <= nib;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     count <= '0;
    else if (load)  count <= latch;
    else if (tick)  count <= step(count, latch);
  end
endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_we,
  input  logic       ack_we,
  input  logic [1:0] ctrl_bits,
  input  logic       wrap,
  output logic [1:0] en,
  output logic       irq
);
  function automatic logic [1:0] ack_enables(input logic [1:0] e);
    return {e[0], e[0]};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       en <= 2'b00;
    else if (ctrl_we) en <= ctrl_bits;
    else if (ack_we)  en <= ack_enables(en);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 irq <= 1'b0;
    else if (ctrl_we || ack_we) irq <= 1'b0;
    else if (wrap)              irq <= 1'b1;
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8,
  parameter int PERIOD = 114,
  localparam int NIB_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_ce,
  input  logic              wr_en,
  input  logic [15:0]       wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              irq_o
);
  logic             lat_lo_we, lat_hi_we, ctrl_we, ack_we;
  logic [NIB_W-1:0] nib;
  logic [1:0]       ctrl_bits;
  logic [1:0]       en;
  logic             clr_evt, load_evt, restart_evt, run_en, tick_evt, wrap_evt;
  logic [CNT_W-1:0] cnt_q, latch_q;

  irqc_decode #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .lat_lo_we(lat_lo_we), .lat_hi_we(lat_hi_we),
    .ctrl_we(ctrl_we), .ack_we(ack_we),
    .nib(nib), .ctrl_bits(ctrl_bits)
  );

  assign clr_evt     = ctrl_we || ack_we;
  assign load_evt    = ctrl_we && ctrl_bits[1];
  assign restart_evt = load_evt || ack_we;
  assign run_en      = en[1] && !clr_evt;

  irqc_prescaler #(.PERIOD(PERIOD)) u_pre (
    .clk(clk), .rst_n(rst_n), .ce(cpu_ce), .run(run_en),
    .restart(restart_evt), .tick(tick_evt)
  );

  irqc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .lat_lo_we(lat_lo_we), .lat_hi_we(lat_hi_we),
    .nib(nib), .load(load_evt), .tick(tick_evt),
    .count(cnt_q), .latch(latch_q), .wrap(wrap_evt)
  );

  irqc_ctrl u_ctl (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ack_we(ack_we),
    .ctrl_bits(ctrl_bits), .wrap(wrap_evt), .en(en), .irq(irq_o)
  );
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int CNT_W  = 8,
  parameter int PERIOD = 114,
  localparam int GW    = $clog2(PERIOD) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_ce,
  input logic             irq_o,
  input logic             tick_evt,
  input logic             wrap_evt,
  input logic             clr_evt,
  input logic             load_evt,
  input logic             ack_we,
  input logic [1:0]       en,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] latch_q
);
  logic [GW-1:0] gap;
  logic          seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap <= '0; seen <= 1'b0;
    end else if (clr_evt) begin
      gap <= '0; seen <= 1'b0;
    end else if (tick_evt) begin
      gap <= '0; seen <= 1'b1;
    end else if (cpu_ce && en[1]) begin
      gap <= gap + 1'b1;
    end
  end

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !clr_evt) |=> irq_o); // R7
  AST_CLEAR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> !irq_o); // R3
  AST_RISE_NEEDS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(wrap_evt)); // R6
  AST_TICK_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_evt && seen) |-> (gap == GW'(PERIOD - 1))); // R5
  AST_LOAD_FROM_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (cnt_q == $past(latch_q))); // R3
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en[1] && !load_evt) |=> $stable(cnt_q)); // R8
  AST_ACK_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    ack_we |=> (en == {2{$past(en[0])}})); // R4
endmodule

bind irqc_top irqc_chk #(.CNT_W(CNT_W), .PERIOD(PERIOD)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .irq_o(irq_o),
  .tick_evt(tick_evt), .wrap_evt(wrap_evt), .clr_evt(clr_evt),
  .load_evt(load_evt), .ack_we(ack_we), .en(en),
  .cnt_q(cnt_q), .latch_q(latch_q)
);

// File: tb/test_irqc_top.sv
`timescale 1ns/1ps
module test_irqc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_ce = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        irq_o;
  logic        ce_alt = 1'b0;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  localparam int PER = 114;

  irqc_top i_irqc_top (
    .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .irq_o(irq_o)
  );

  always #5 clk = ~clk;
  always @(negedge clk) cpu_ce <= ce_alt ? ~cpu_ce : 1'b1;

  function automatic int expect_ce(input int l);
    return 1 + (255 - l) * PER;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic wait_irq(input int limit, output int n_ce, output int n_clk);
    n_ce = 0; n_clk = 0;
    while (n_clk < limit) begin
      @(posedge clk); #1;
      n_clk++;
      if (cpu_ce) n_ce++;
      if (irq_o) break;
    end
  endtask

  task automatic stay(input int n, input bit lvl, input string req);
    int bad = 0;
    repeat (n) begin
      @(posedge clk); #1;
      if (irq_o !== lvl) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic t_reset();
    chk(irq_o === 1'b0, "R1 irq low after reset", irq_o, 0);
    stay(300, 1'b0, "R1 no request before control write");
  endtask

  task automatic t_basic();
    int nc, nk;
    bus_wr(16'hF000, 8'hAD);
    bus_wr(16'hF002, 8'h5F);
    bus_wr(16'hF004, 8'h02);
    wait_irq(2000, nc, nk);
    chk(nk == expect_ce(8'hFD), "R2 R6 R10 wrap timing latch FD", nk, expect_ce(8'hFD));
    stay(700, 1'b1, "R7 request sticky over later wraps");
    bus_wr(16'hF080, 8'h00);
    chk(irq_o === 1'b0, "R3 control clears request", irq_o, 0);
    stay(400, 1'b0, "R8 disabled counter stays quiet");
  endtask

  task automatic t_ignore();
    int nc, nk;
    bus_wr(16'hF001, 8'hFF);
    bus_wr(16'hF005, 8'hFF);
    bus_wr(16'hF008, 8'h03);
    stay(400, 1'b0, "R9 undecoded writes start nothing");
    bus_wr(16'hF004, 8'h02);
    wait_irq(2000, nc, nk);
    chk(nk == expect_ce(8'hFD), "R9 latch untouched by undecoded writes", nk, expect_ce(8'hFD));
    bus_wr(16'hF004, 8'h00);
  endtask

  task automatic t_alias();
    int nc, nk;
    bus_wr(16'hF840, 8'h0F);
    bus_wr(16'hF800, 8'h3E);
    bus_wr(16'hF880, 8'h02);
    wait_irq(2000, nc, nk);
    chk(nk == expect_ce(8'hFE), "R9 R2 mirrored addresses", nk, expect_ce(8'hFE));
    bus_wr(16'hF004, 8'h00);
  endtask

  task automatic t_ack();
    int nc, nk;
    bus_wr(16'hF004, 8'h03);
    wait_irq(2000, nc, nk);
    chk(nk == expect_ce(8'hFE), "R6 first wrap with repeat set", nk, expect_ce(8'hFE));
    bus_wr(16'hF006, 8'h00);
    chk(irq_o === 1'b0, "R4 acknowledge clears request", irq_o, 0);
    wait_irq(2000, nc, nk);
    chk(nk == expect_ce(8'hFE), "R4 repeat keeps counting after acknowledge", nk, expect_ce(8'hFE));
    bus_wr(16'hF0C0, 8'h00);
    chk(irq_o === 1'b0, "R4 acknowledge mirror clears", irq_o, 0);
    bus_wr(16'hF004, 8'h02);
    wait_irq(2000, nc, nk);
    chk(nk == expect_ce(8'hFE), "R3 load with repeat clear", nk, expect_ce(8'hFE));
    bus_wr(16'hF003, 8'h00);
    chk(irq_o === 1'b0, "R4 acknowledge third address", irq_o, 0);
    stay(400, 1'b0, "R4 no repeat stops counting");
  endtask

  task automatic t_hold();
    int nc, nk;
    bus_wr(16'hF000, 8'h00);
    bus_wr(16'hF002, 8'h0F);
    bus_wr(16'hF004, 8'h02);
    repeat (230) @(posedge clk);
    bus_wr(16'hF004, 8'h01);
    stay(500, 1'b0, "R8 counter frozen while run bit clear");
    bus_wr(16'hF003, 8'h00);
    wait_irq(3000, nc, nk);
    chk(nk == expect_ce(8'hF3), "R8 R4 resume without reload", nk, expect_ce(8'hF3));
    bus_wr(16'hF004, 8'h00);
  endtask

  task automatic t_ce_gap();
    int nc, nk;
    ce_alt = 1'b1;
    bus_wr(16'hF000, 8'h0D);
    bus_wr(16'hF002, 8'h0F);
    bus_wr(16'hF004, 8'h02);
    wait_irq(3000, nc, nk);
    chk(nc == expect_ce(8'hFD), "R5 only CPU cycles counted", nc, expect_ce(8'hFD));
    chk(nk > nc, "R5 idle cycles skipped", nk, nc);
    bus_wr(16'hF004, 8'h00);
    ce_alt = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_basic();
    t_ignore();
    t_alias();
    t_ack();
    t_hold();
    t_ce_gap();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule